// File: doc/BRIEF.md
# Mobile Low-Power SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a mobile low-power DDR SDRAM interface. It takes the memory from a powered, clock-stable condition to a state where it accepts normal commands. When the block receives a start pulse with a legal configuration, it raises the clock-enable pin. It then holds the command bus at no-operation for a long stable-clock interval. After that it issues a precharge of every bank and two auto-refresh commands. Last, it loads the two mode registers: the standard one first, then the extended one. A timed wait follows every command. Every wait is counted in controller clock cycles, and each length is set by a parameter.

The burst length, burst type, CAS latency, output drive strength and self-refresh array coverage arrive as raw code inputs. The block builds the two mode-register words from these codes when it accepts a start. It flags any reserved code combinationally and refuses to start while the flag is raised. When the last wait ends, `done` rises. From then on the block keeps the bus at no-operation until reset, which stands in for a loss of power.

Top module: `lpddr_init_seq`

## Requirements
- R1: While reset is high, and afterwards until a start is accepted, `cke`=0, `done`=0 and the bus shows NOP, which is `{cs_n,ras_n,cas_n,we_n}`=0111 with `ba` and `addr` at zero. Reset is synchronous.
- R2: A start is accepted when `start`=1 and `cfg_err`=0 at a clock edge in the idle state. From the next cycle `cke`=1, and exactly T_INIT_CYC NOP cycles come before the first command. No command other than NOP is ever driven while `cke`=0.
- R3: The first command is precharge-all, encoded `{cs_n,ras_n,cas_n,we_n}`=0010 with `addr[10]`=1. It is followed by exactly T_RP_CYC NOP cycles.
- R4: Exactly two auto-refresh commands come next, each encoded 0001. Each is followed by exactly T_RFC_CYC NOP cycles.
- R5: Next comes a load-mode command, encoded 0000, with `ba`=00 that carries the standard word. It is followed by exactly T_MRD_CYC NOP cycles.
- R6: Next comes a load-mode command with `ba`=10 (`ba[1]`=1) that carries the extended word. It is followed by exactly T_MRD_CYC NOP cycles with `done`=0.
- R7: The standard word is `addr[2:0]`=burst-length code, `addr[3]`=burst type (1 means interleaved), `addr[6:4]`=CAS-latency code. All higher address bits are zero.
- R8: The extended word is `addr[2:0]`=coverage code, `addr[4:3]`=00, `addr[7:5]`=drive-strength code. All higher address bits are zero.
- R9: `cfg_err` is combinational. It is 1 exactly when any code is reserved. The legal burst-length codes are 1, 2, 3 and 4. The legal CAS-latency codes are 2 and 3. The legal drive-strength codes are 0 to 4. The legal coverage codes are 0, 1, 2, 5 and 6.
- R10: A start while `cfg_err`=1 is ignored: `cke` stays 0 and the bus stays at NOP.
- R11: `start` pulses after acceptance are ignored, as are code changes after acceptance. The sequence timing and both mode words match the values captured at acceptance.
- R12: After R6, `done`=1, `cke`=1 and the bus stays at NOP until reset. A reset in the middle of the sequence returns the block to the R1 state, and a new start then runs the full sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high (power interruption) |
| start | input | 1 | Begin initialization (accepted only when idle) |
| bl_code | input | 3 | Burst-length code |
| bt_interleave | input | 1 | Burst type, 1 = interleaved |
| cl_code | input | 3 | CAS-latency code |
| ds_code | input | 3 | Drive-strength code |
| pasr_code | input | 3 | Self-refresh array coverage code |
| cke | output | 1 | Clock enable to memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | ADDR_W | Address bus |
| cfg_err | output | 1 | Reserved code present on the inputs |
| done | output | 1 | Initialization complete |

## Verification
The command bus is decoded straight from the state register, so a wrong state appears on `cs_n`/`ras_n`/`cas_n`/`we_n`, `cke` or `done` in the same cycle it is entered. A counter that reloads or expires wrongly shows up at the next command edge as a NOP run longer or shorter than its parameter. For that reason the bench counts the NOP cycles between every pair of commands exactly, instead of only checking the order. A capture fault in the mode words appears only during the single cycle of each load-mode command. The bench therefore checks `ba` and `addr` in exactly those cycles.

// File: rtl/lpinit_pkg.sv
package lpinit_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_W_INIT,
      ST_PREA,
      ST_W_RP,
      ST_REF1,
      ST_W_RFC1,
      ST_REF2,
      ST_W_RFC2,
      ST_LMR_STD,
      ST_W_MRD1,
      ST_LMR_EXT,
      ST_W_MRD2,
      ST_DONE
   } seq_state_t;

   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
   } cmd_t;

   localparam cmd_t CMD_NOP  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
   localparam cmd_t CMD_PREA = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
   localparam cmd_t CMD_REF  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
   localparam cmd_t CMD_LMR  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

   localparam int unsigned STD_W = 7;
   localparam int unsigned EXT_W = 8;

   function automatic logic bl_legal(input logic [2:0] c);
      return (c == 3'd1) || (c == 3'd2) || (c == 3'd3) || (c == 3'd4);
   endfunction

   function automatic logic cl_legal(input logic [2:0] c);
      return (c == 3'd2) || (c == 3'd3);
   endfunction

   function automatic logic ds_legal(input logic [2:0] c);
      return c <= 3'd4;
   endfunction

   function automatic logic pasr_legal(input logic [2:0] c);
      return (c == 3'd0) || (c == 3'd1) || (c == 3'd2) || (c == 3'd5) || (c == 3'd6);
   endfunction

endpackage

// File: rtl/lpinit_timer.sv
module lpinit_timer #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

   AST_TMR_COUNTS_DOWN: assert property (@(posedge clk) disable iff (rst)
      (!$past(load) && !$past(rst) && $past(cnt_q) != '0) |-> (cnt_q < $past(cnt_q))); // R2

endmodule

// File: rtl/lpinit_modes.sv
module lpinit_modes
   import lpinit_pkg::*;
#(
   parameter int unsigned ADDR_W = 13
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              capture,
   input  logic [2:0]        bl_code,
   input  logic              bt_interleave,
   input  logic [2:0]        cl_code,
   input  logic [2:0]        ds_code,
   input  logic [2:0]        pasr_code,
   output logic              cfg_err,
   output logic [ADDR_W-1:0] std_word,
   output logic [ADDR_W-1:0] ext_word
);

   localparam int unsigned PAD_STD = ADDR_W - STD_W;
   localparam int unsigned PAD_EXT = ADDR_W - EXT_W;

   if (ADDR_W < 11) begin : g_addr_too_narrow
      $error("lpinit_modes: ADDR_W must be at least 11");
   end

   logic [STD_W-1:0] std_q;
   logic [EXT_W-1:0] ext_q;

   assign cfg_err = !(bl_legal(bl_code) && cl_legal(cl_code) &&
                      ds_legal(ds_code) && pasr_legal(pasr_code));

   always_ff @(posedge clk) begin
      if (rst) begin
         std_q <= '0;
         ext_q <= '0;
      end else if (capture) begin
         std_q <= {cl_code, bt_interleave, bl_code};
         ext_q <= {ds_code, 2'b00, pasr_code};
      end
   end

   assign std_word = {{PAD_STD{1'b0}}, std_q};
   assign ext_word = {{PAD_EXT{1'b0}}, ext_q};

   AST_CAPTURE_LEGAL: assert property (@(posedge clk) disable iff (rst)
      capture |-> !cfg_err); // R10

endmodule

// File: rtl/lpddr_init_seq.sv
module lpddr_init_seq
   import lpinit_pkg::*;
#(
   parameter int unsigned ADDR_W     = 13,
   parameter int unsigned T_INIT_CYC = 20000,
   parameter int unsigned T_RP_CYC   = 3,
   parameter int unsigned T_RFC_CYC  = 11,
   parameter int unsigned T_MRD_CYC  = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [2:0]        bl_code,
   input  logic              bt_interleave,
   input  logic [2:0]        cl_code,
   input  logic [2:0]        ds_code,
   input  logic [2:0]        pasr_code,
   output logic              cke,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [1:0]        ba,
   output logic [ADDR_W-1:0] addr,
   output logic              cfg_err,
   output logic              done
);

   localparam int unsigned T_A   = (T_INIT_CYC > T_RP_CYC) ? T_INIT_CYC : T_RP_CYC;
   localparam int unsigned T_B   = (T_RFC_CYC > T_MRD_CYC) ? T_RFC_CYC : T_MRD_CYC;
   localparam int unsigned T_MAX = (T_A > T_B) ? T_A : T_B;
   localparam int unsigned CNT_W = $clog2(T_MAX + 1);

   if (T_INIT_CYC < 1 || T_RP_CYC < 1 || T_RFC_CYC < 1 || T_MRD_CYC < 1) begin : g_bad_wait
      $error("lpddr_init_seq: every wait length must be at least one cycle");
   end

   seq_state_t       state_q, state_d;
   logic             go;
   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             tmr_expired;
   logic [ADDR_W-1:0] std_word, ext_word;
   cmd_t             cmd;

   lpinit_modes #(.ADDR_W(ADDR_W)) u_modes (
      .clk           (clk),
      .rst           (rst),
      .capture       (go),
      .bl_code       (bl_code),
      .bt_interleave (bt_interleave),
      .cl_code       (cl_code),
      .ds_code       (ds_code),
      .pasr_code     (pasr_code),
      .cfg_err       (cfg_err),
      .std_word      (std_word),
      .ext_word      (ext_word)
   );

   lpinit_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst      (rst),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_expired)
   );

   assign go = (state_q == ST_IDLE) && start && !cfg_err;

   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (state_q)
         ST_IDLE:    begin tmr_load = go;   tmr_val = CNT_W'(T_INIT_CYC - 1); end
         ST_PREA:    begin tmr_load = 1'b1; tmr_val = CNT_W'(T_RP_CYC - 1);   end
         ST_REF1,
         ST_REF2:    begin tmr_load = 1'b1; tmr_val = CNT_W'(T_RFC_CYC - 1);  end
         ST_LMR_STD,
         ST_LMR_EXT: begin tmr_load = 1'b1; tmr_val = CNT_W'(T_MRD_CYC - 1);  end
         default:    begin tmr_load = 1'b0; tmr_val = '0;                     end
      endcase
   end

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:    if (go)          state_d = ST_W_INIT;
         ST_W_INIT:  if (tmr_expired) state_d = ST_PREA;
         ST_PREA:                     state_d = ST_W_RP;
         ST_W_RP:    if (tmr_expired) state_d = ST_REF1;
         ST_REF1:                     state_d = ST_W_RFC1;
         ST_W_RFC1:  if (tmr_expired) state_d = ST_REF2;
         ST_REF2:                     state_d = ST_W_RFC2;
         ST_W_RFC2:  if (tmr_expired) state_d = ST_LMR_STD;
         ST_LMR_STD:                  state_d = ST_W_MRD1;
         ST_W_MRD1:  if (tmr_expired) state_d = ST_LMR_EXT;
         ST_LMR_EXT:                  state_d = ST_W_MRD2;
         ST_W_MRD2:  if (tmr_expired) state_d = ST_DONE;
         ST_DONE:                     state_d = ST_DONE;
         default:                     state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state_q <= ST_IDLE;
      else     state_q <= state_d;
   end

   always_comb begin
      cmd  = CMD_NOP;
      ba   = 2'b00;
      addr = '0;
      unique case (state_q)
         ST_PREA:          begin cmd = CMD_PREA; addr[10] = 1'b1;       end
         ST_REF1, ST_REF2: begin cmd = CMD_REF;                         end
         ST_LMR_STD:       begin cmd = CMD_LMR; addr = std_word;        end
         ST_LMR_EXT:       begin cmd = CMD_LMR; ba = 2'b10; addr = ext_word; end
         default:          begin cmd = CMD_NOP;                         end
      endcase
   end

   assign cs_n  = cmd.cs_n;
   assign ras_n = cmd.ras_n;
   assign cas_n = cmd.cas_n;
   assign we_n  = cmd.we_n;
   assign cke   = (state_q != ST_IDLE);
   assign done  = (state_q == ST_DONE);

   AST_CMD_NEEDS_CKE: assert property (@(posedge clk) disable iff (rst)
      ({cs_n, ras_n, cas_n, we_n} != 4'b0111) |-> cke); // R2

   AST_WAIT_EXIT_ON_EXPIRY: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && state_q != ST_IDLE && state_q != $past(state_q) &&
       ($past(state_q) == ST_W_INIT || $past(state_q) == ST_W_RP ||
        $past(state_q) == ST_W_RFC1 || $past(state_q) == ST_W_RFC2 ||
        $past(state_q) == ST_W_MRD1 || $past(state_q) == ST_W_MRD2))
      |-> $past(tmr_expired)); // R3

   AST_LMR_BA0_LOW: assert property (@(posedge clk) disable iff (rst)
      (!ras_n && !cas_n && !we_n) |-> (ba[0] == 1'b0)); // R5

   AST_ERR_BLOCKS_START: assert property (@(posedge clk) disable iff (rst)
      (!cke && start && cfg_err) |=> !cke); // R10

   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
      done |=> done); // R12

   AST_DONE_BUS_NOP: assert property (@(posedge clk) disable iff (rst)
      done |-> ({cs_n, ras_n, cas_n, we_n} == 4'b0111 && cke)); // R12

endmodule

// File: tb/lpddr_init_seq_tb.sv
module lpddr_init_seq_tb;

   localparam int CLK_PERIOD = 10;
   localparam int AW     = 13;
   localparam int T_INIT = 25;
   localparam int T_RP   = 3;
   localparam int T_RFC  = 6;
   localparam int T_MRD  = 2;

   logic          clk = 1'b0;
   logic          rst, start, bt_interleave;
   logic [2:0]    bl_code, cl_code, ds_code, pasr_code;
   logic          cke, cs_n, ras_n, cas_n, we_n, cfg_err, done;
   logic [1:0]    ba;
   logic [AW-1:0] addr;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lpddr_init_seq #(
      .ADDR_W(AW), .T_INIT_CYC(T_INIT), .T_RP_CYC(T_RP),
      .T_RFC_CYC(T_RFC), .T_MRD_CYC(T_MRD)
   ) u_dut (
      .clk(clk), .rst(rst), .start(start), .bl_code(bl_code),
      .bt_interleave(bt_interleave), .cl_code(cl_code), .ds_code(ds_code),
      .pasr_code(pasr_code), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
      .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
      .cfg_err(cfg_err), .done(done)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic bit bus_nop();
      return ({cs_n, ras_n, cas_n, we_n} == 4'b0111);
   endfunction

   function automatic bit legal(input logic [2:0] bl, cl, ds, ps);
      return (bl >= 3'd1 && bl <= 3'd4) && (cl == 3'd2 || cl == 3'd3) &&
             (ds <= 3'd4) && (ps inside {3'd0, 3'd1, 3'd2, 3'd5, 3'd6});
   endfunction

   task automatic count_nops(output int n);
      n = 0;
      while (bus_nop() && n < 1000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; start = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk(!cke && !done && bus_nop() && ba == 2'b00 && addr == '0, "R1",
          {cke, done, cs_n, ras_n, cas_n, we_n}, 32'h7);
      rst = 1'b0;
   endtask

   task automatic run_seq(input logic [2:0] bl, input logic bt, input logic [2:0] cl,
                          input logic [2:0] ds, input logic [2:0] ps, input bit disturb);
      int n;
      logic [AW-1:0] exp_std, exp_ext;
      exp_std = AW'({cl, bt, bl});
      exp_ext = AW'({ds, 2'b00, ps});
      bl_code = bl; bt_interleave = bt; cl_code = cl; ds_code = ds; pasr_code = ps;
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (disturb) begin
         start = 1'b1; bl_code = 3'd1; bt_interleave = ~bt; cl_code = 3'd2;
         ds_code = 3'd1; pasr_code = 3'd5;
      end
      chk(cke && !done, "R2", {cke, done}, 32'h2);
      count_nops(n);
      chk(n == T_INIT, "R2", n, T_INIT);
      chk({cs_n, ras_n, cas_n, we_n} == 4'b0010 && addr[10], "R3", {cs_n, ras_n, cas_n, we_n, addr[10]}, 32'h5);
      @(negedge clk);
      count_nops(n);
      chk(n == T_RP, "R3", n, T_RP);
      for (int r = 0; r < 2; r++) begin
         chk({cs_n, ras_n, cas_n, we_n} == 4'b0001, "R4", {cs_n, ras_n, cas_n, we_n}, 32'h1);
         @(negedge clk);
         count_nops(n);
         chk(n == T_RFC, "R4", n, T_RFC);
      end
      chk({cs_n, ras_n, cas_n, we_n} == 4'b0000 && ba == 2'b00, "R5", {cs_n, ras_n, cas_n, we_n, ba}, 32'h0);
      chk(addr == exp_std, disturb ? "R11" : "R7", addr, exp_std);
      @(negedge clk);
      count_nops(n);
      chk(n == T_MRD, "R5", n, T_MRD);
      chk({cs_n, ras_n, cas_n, we_n} == 4'b0000 && ba == 2'b10, "R6", {cs_n, ras_n, cas_n, we_n, ba}, 32'h2);
      chk(addr == exp_ext, disturb ? "R11" : "R8", addr, exp_ext);
      @(negedge clk);
      for (int i = 0; i < T_MRD; i++) begin
         chk(bus_nop() && !done && cke, "R6", {done, cs_n, ras_n, cas_n, we_n}, 32'h7);
         @(negedge clk);
      end
      chk(done && cke && bus_nop(), "R12", {done, cke, cs_n, ras_n, cas_n, we_n}, 32'h37);
      start = 1'b0;
   endtask

   task automatic t_reset_idle();
      do_reset();
      repeat (6) @(negedge clk);
      chk(!cke && !done && bus_nop(), "R1", {cke, done}, 32'h0);
   endtask

   task automatic t_cfg_err();
      bit bad_seen = 1'b0;
      for (int b = 0; b < 8; b++) begin
         for (int f = 0; f < 4; f++) begin
            bl_code = 3'd3; cl_code = 3'd3; ds_code = 3'd0; pasr_code = 3'd0;
            case (f)
               0: bl_code   = 3'(b);
               1: cl_code   = 3'(b);
               2: ds_code   = 3'(b);
               default: pasr_code = 3'(b);
            endcase
            #1;
            chk(cfg_err == !legal(bl_code, cl_code, ds_code, pasr_code), "R9",
                cfg_err, !legal(bl_code, cl_code, ds_code, pasr_code));
         end
      end
      do_reset();
      bl_code = 3'd3; cl_code = 3'd1; ds_code = 3'd0; pasr_code = 3'd0;
      @(negedge clk);
      start = 1'b1;
      repeat (3) @(negedge clk);
      start = 1'b0;
      repeat (T_INIT + 4) begin
         @(negedge clk);
         if (cke || !bus_nop() || done) bad_seen = 1'b1;
      end
      chk(!bad_seen, "R10", bad_seen, 0);
   endtask

   task automatic t_mid_reset();
      do_reset();
      bl_code = 3'd2; bt_interleave = 1'b0; cl_code = 3'd2; ds_code = 3'd2; pasr_code = 3'd1;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (T_INIT + 4) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk(!cke && !done && bus_nop(), "R12", {cke, done}, 32'h0);
      rst = 1'b0;
      repeat (3) @(negedge clk);
      chk(!cke && bus_nop(), "R1", cke, 0);
      run_seq(3'd2, 1'b0, 3'd2, 3'd2, 3'd1, 1'b0);
   endtask

   task automatic t_done_hold();
      bit bad_seen = 1'b0;
      start = 1'b1;
      repeat (12) begin
         @(negedge clk);
         if (!done || !cke || !bus_nop()) bad_seen = 1'b1;
      end
      start = 1'b0;
      chk(!bad_seen, "R12", bad_seen, 0);
   endtask

   initial begin
      rst = 1'b1; start = 1'b0; bt_interleave = 1'b0;
      bl_code = 3'd3; cl_code = 3'd3; ds_code = 3'd0; pasr_code = 3'd0;
      t_reset_idle();
      t_cfg_err();
      do_reset();
      run_seq(3'd3, 1'b0, 3'd3, 3'd0, 3'd0, 1'b0);
      t_done_hold();
      do_reset();
      run_seq(3'd4, 1'b1, 3'd2, 3'd4, 3'd6, 1'b0);
      t_mid_reset();
      do_reset();
      run_seq(3'd1, 1'b1, 3'd3, 3'd3, 3'd2, 1'b1);
      t_done_hold();
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule